// File: doc/BRIEF.md
# Two-Wire Paged Memory Slave

A slave on a two-wire serial bus (clock line plus open-drain data line) that fronts a 2048-byte memory kept in internal registers. A transaction opens with a START, followed by an address byte. That byte holds a fixed type code, two device-select bits that must equal the strap inputs, and a read/write flag. Write transactions then carry a two-byte word address and up to a page of data. Read transactions stream bytes back from an internal pointer, either directly or after a dummy write has set the pointer.

Write data is collected in a page buffer and is committed only when a STOP arrives. A simulated self-timed write cycle of a fixed number of clocks then copies the buffer into the memory. While that cycle runs, the slave does not answer its own address, so a host can poll for completion. An external protect input, sampled at the STOP, can veto the commit. The slave samples both lines through synchronizers on its own clock, and it only ever pulls the data line low.

Top module: `twi_mem_slave`

## Requirements
- R1: An address byte is accepted only when bits [7:4] = 4'b1010, bit 3 = 0 and bits [2:1] equal sel_i; bit 0 = 1 selects read. Any other byte gets no acknowledge, and the slave stays silent until the next START.
- R2: Each accepted address, word-address or write-data byte is acknowledged by holding SDA low through the ninth clock of that byte.
- R3: The slave changes its SDA drive only while SCL is low.
- R4: The word address is two bytes, high byte first. The memory location is the low ADDR_W (11) bits of that 16-bit value, so the upper bits are ignored.
- R5: A byte write (address, one data byte, STOP) stores that byte.
- R6: A page write accepts any number of bytes. The pointer's low 6 bits wrap inside the 64-byte page, so a later byte overwrites an earlier one at the same offset.
- R7: Data is committed only on STOP. A repeated START before the STOP discards the pending bytes, and no write cycle follows.
- R8: After a committed write, the address byte is not acknowledged for TWR_CYC clocks. After that it is acknowledged again.
- R9: If wr_block_i is high when the STOP is seen, the data bytes are still acknowledged, but the memory is unchanged and no write cycle starts.
- R10: A random read (write address, then word address, then repeated START, then read address) returns the byte at that word address.
- R11: A current-address read returns the byte at the internal pointer. After a write, the pointer is one past the last written offset, wrapped within the page.
- R12: A sequential read advances the pointer after each byte, and wraps from address 2047 to 0. A master no-acknowledge ends the read, and SDA is released.
- R13: After reset, SDA is released and no write cycle is running, so the first address byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sel_i | input | 2 | Device-select straps compared with address bits [2:1] |
| wr_block_i | input | 1 | Protect result; high at STOP vetoes the commit |

## Verification
A wrong pointer shows up at the ports on the very next read byte, or on the current-address read after a page write. A wrong page-buffer valid mask shows up only after the write cycle ends, when the page is read back sequentially. A busy flag that is stuck, or that ends early, changes the first acknowledge-polling attempt after a STOP, within one address byte. A lost acknowledge shows up on the ninth clock of the byte that suffered it.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_IGN
  } proto_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] BIT_ACK  = 4'd8;   // rises counted when the ninth clock starts
  localparam logic [3:0] BIT_END  = 4'd9;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_i};
      sda_ff <= {sda_ff[TOP-1:0], sda_i};
      scl_q  <= scl_ff[TOP];
      sda_q  <= sda_ff[TOP];
    end
  end

  assign sda_s_o    = sda_ff[TOP];
  assign scl_rise_o = scl_ff[TOP] & ~scl_q;
  assign scl_fall_o = ~scl_ff[TOP] & scl_q;
  assign start_o    = scl_ff[TOP] & scl_q & sda_q & ~sda_ff[TOP];
  assign stop_o     = scl_ff[TOP] & scl_q & ~sda_q & sda_ff[TOP];
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_mem_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_s_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [1:0]    sel_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] ptr_o,
  output logic          buf_we_o,
  output logic [PW-1:0] buf_off_o,
  output logic [7:0]    buf_data_o
);
  localparam int HI_W = AW - 8;
  localparam logic [PW-1:0] OFF_ONE = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

  proto_st_e       st;
  logic [3:0]      bit_cnt;
  logic [7:0]      sh_rx, sh_tx;
  logic [HI_W-1:0] wa_hi;
  logic            rd_mode, m_ack;
  logic            dev_hit;
  logic [AW-1:0]   ptr_pg_inc;

  assign dev_hit = (sh_rx[7:4] == DEV_TYPE) && !sh_rx[3] &&
                   (sh_rx[2:1] == sel_i) && !busy_i;
  assign ptr_pg_inc = {ptr_o[AW-1:PW], ptr_o[PW-1:0] + OFF_ONE};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      sh_rx      <= '0;
      sh_tx      <= '0;
      wa_hi      <= '0;
      rd_mode    <= 1'b0;
      m_ack      <= 1'b0;
      sda_oe_o   <= 1'b0;
      ptr_o      <= '0;
      buf_we_o   <= 1'b0;
      buf_off_o  <= '0;
      buf_data_o <= '0;
    end else begin
      buf_we_o <= 1'b0;
      if (start_i) begin
        st       <= ST_DEV;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (st != ST_IDLE && st != ST_IGN) begin
        if (scl_rise_i) begin
          if (bit_cnt != BIT_END) bit_cnt <= bit_cnt + 4'd1;
          sh_rx <= {sh_rx[6:0], sda_s_i};
          if (bit_cnt == BIT_ACK) m_ack <= ~sda_s_i;
        end else if (scl_fall_i) begin
          if (bit_cnt == BIT_ACK) begin
            case (st)
              ST_DEV: begin
                if (dev_hit) begin
                  sda_oe_o <= 1'b1;
                  rd_mode  <= sh_rx[0];
                end else begin
                  st <= ST_IGN;
                end
              end
              ST_AHI: begin
                sda_oe_o <= 1'b1;
                wa_hi    <= sh_rx[HI_W-1:0];
              end
              ST_ALO: begin
                sda_oe_o <= 1'b1;
                ptr_o    <= {wa_hi, sh_rx};
              end
              ST_WR: begin
                sda_oe_o   <= 1'b1;
                buf_we_o   <= 1'b1;
                buf_off_o  <= ptr_o[PW-1:0];
                buf_data_o <= sh_rx;
                ptr_o      <= ptr_pg_inc;
              end
              ST_RD: begin
                sda_oe_o <= 1'b0;   // master drives the ninth clock
                ptr_o    <= ptr_o + PTR_ONE;
              end
              default: ;
            endcase
          end else if (bit_cnt == BIT_END) begin
            bit_cnt <= '0;
            case (st)
              ST_DEV: begin
                if (rd_mode) begin
                  st       <= ST_RD;
                  sh_tx    <= {rd_data_i[6:0], 1'b0};
                  sda_oe_o <= ~rd_data_i[7];
                end else begin
                  st       <= ST_AHI;
                  sda_oe_o <= 1'b0;
                end
              end
              ST_AHI: begin
                st       <= ST_ALO;
                sda_oe_o <= 1'b0;
              end
              ST_ALO, ST_WR: begin
                st       <= ST_WR;
                sda_oe_o <= 1'b0;
              end
              ST_RD: begin
                if (m_ack) begin
                  sh_tx    <= {rd_data_i[6:0], 1'b0};
                  sda_oe_o <= ~rd_data_i[7];
                end else begin
                  st       <= ST_IGN;
                  sda_oe_o <= 1'b0;
                end
              end
              default: ;
            endcase
          end else if (st == ST_RD) begin
            sda_oe_o <= ~sh_tx[7];
            sh_tx    <= {sh_tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
  parameter int AW      = 11,
  parameter int PW      = 6,
  parameter int TWR_CYC = 5000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             buf_we_i,
  input  logic [PW-1:0]    buf_off_i,
  input  logic [7:0]       buf_data_i,
  input  logic [AW-PW-1:0] page_i,
  input  logic             discard_i,
  input  logic             commit_i,
  input  logic             block_i,
  output logic             busy_o,
  output logic             mem_we_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int CW    = $clog2(TWR_CYC + 1);
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE);
  localparam logic [CW-1:0] LAST_C = CW'(TWR_CYC - 1);
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PAGE];
  logic [PAGE-1:0]  vld;
  logic [AW-PW-1:0] pg_q;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    off;

  assign off       = cnt[PW-1:0];
  assign mem_we_o  = busy_o && (cnt < PAGE_C) && vld[off];
  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld    <= '0;
      busy_o <= 1'b0;
      pg_q   <= '0;
      cnt    <= '0;
    end else if (busy_o) begin
      // polling traffic during the cycle must not touch the pending page
      cnt <= cnt + CNT_ONE;
      if (cnt == LAST_C) begin
        busy_o <= 1'b0;
        vld    <= '0;
      end
    end else if (discard_i) begin
      vld <= '0;
    end else if (commit_i) begin
      if (|vld) begin
        if (block_i) begin
          vld <= '0;
        end else begin
          busy_o <= 1'b1;
          cnt    <= '0;
          pg_q   <= page_i;
        end
      end
    end else if (buf_we_i) begin
      vld[buf_off_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (buf_we_i) pbuf[buf_off_i] <= buf_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (mem_we_o) mem[{pg_q, off}] <= pbuf[off];
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int TWR_CYC     = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] sel_i,
  input  logic       wr_block_i
);
  logic              sda_s, scl_rise, scl_fall, start, stop;
  logic              busy, mem_we, buf_we;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rd_data, buf_data;
  logic [PAGE_W-1:0] buf_off;

  twi_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  twi_proto_fsm #(.AW(ADDR_W), .PW(PAGE_W)) u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_s_i(sda_s),
    .start_i(start), .stop_i(stop), .sel_i, .busy_i(busy),
    .rd_data_i(rd_data), .sda_oe_o,
    .ptr_o(ptr), .buf_we_o(buf_we), .buf_off_o(buf_off), .buf_data_o(buf_data)
  );

  twi_page_store #(.AW(ADDR_W), .PW(PAGE_W), .TWR_CYC(TWR_CYC)) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i(ptr), .rd_data_o(rd_data),
    .buf_we_i(buf_we), .buf_off_i(buf_off), .buf_data_i(buf_data),
    .page_i(ptr[ADDR_W-1:PAGE_W]),
    .discard_i(start), .commit_i(stop), .block_i(wr_block_i),
    .busy_o(busy), .mem_we_o(mem_we)
  );
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int TWR_CYC = 5000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy,
  input logic mem_we,
  input logic wr_block_i
);
  int busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else         busy_cnt <= busy ? busy_cnt + 1 : 0;
  end

  a_r3_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r8_silent_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  a_r8_cycle_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> busy_cnt == TWR_CYC);

  a_r7_write_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy);

  a_r9_block_no_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wr_block_i));
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.TWR_CYC(TWR_CYC)) u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o,
  .busy(busy), .mem_we(mem_we), .wr_block_i
);

// File: tb/twi_mem_slave_test.sv
module twi_mem_slave_test;
  localparam int CLK_P = 10;
  localparam int Q     = 5;
  localparam int TWR   = 300;
  localparam int AW    = 11;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, wr_block = 1'b0;
  logic [1:0] sel = 2'b10;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int total = 0, bad = 0, r3_bad = 0;
  logic [7:0] ref_mem [1 << AW];
  logic [7:0] wbuf [128];
  logic [7:0] rbuf [128];
  logic prev_oe = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  twi_mem_slave #(.ADDR_W(AW), .PAGE_W(6), .TWR_CYC(TWR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .sel_i(sel), .wr_block_i(wr_block)
  );

  // R3 monitor: slave drive may move only while SCL is low
  always @(negedge clk) begin
    if (sda_oe !== prev_oe && scl) r3_bad++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] dev_byte(input bit rd);
    return {4'hA, 1'b0, sel, rd};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; tq();
    scl = 1'b1; tq();
    m_sda = 1'b0; tq();
    scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tq();
    scl = 1'b1; tq();
    m_sda = 1'b1; tq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tq();
      scl = 1'b1; tq(); tq();
      scl = 1'b0;
    end
    m_sda = 1'b1; tq();
    scl = 1'b1; tq();
    ack = !sda_line; tq();
    scl = 1'b0; tq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; tq();
      b[i] = sda_line; tq();
      scl = 1'b0; tq();
    end
    m_sda = !give_ack; tq();
    scl = 1'b1; tq(); tq();
    scl = 1'b0; tq();
    m_sda = 1'b1;
  endtask

  task automatic addr_write(input logic [15:0] wa, output bit ok);
    bit a0, a1, a2;
    bus_start();
    put_byte(dev_byte(1'b0), a0);
    put_byte(wa[15:8], a1);
    put_byte(wa[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic poll_ready(output int nacks);
    bit a;
    nacks = 0;
    for (int k = 0; k < 100; k++) begin
      bus_start();
      put_byte(dev_byte(1'b0), a);
      bus_stop();
      if (a) break;
      nacks++;
    end
  endtask

  task automatic do_write(input logic [15:0] wa, input int n, input string req);
    bit ok, a;
    addr_write(wa, ok);
    chk(ok, "R2", "address phase ack", ok, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a);
      chk(a, req, "data byte ack", a, 1);
    end
    bus_stop();
  endtask

  // leaves the bus open after the final no-acknowledge
  task automatic rand_read(input logic [15:0] wa, input int n);
    bit ok, a;
    addr_write(wa, ok);
    chk(ok, "R10", "dummy write ack", ok, 1);
    bus_start();
    put_byte(dev_byte(1'b1), a);
    chk(a, "R10", "read address ack", a, 1);
    for (int i = 0; i < n; i++) get_byte(i < n - 1, rbuf[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all: act=0x1 exp=0x0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nacks;
    bit a, ok;
    logic [10:0] base;

    repeat (4) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0, "R13", "SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tq();
    chk(sda_oe == 1'b0, "R13", "SDA released after reset", sda_oe, 0);
    poll_ready(nacks);
    chk(nacks == 0, "R13", "no cycle after reset", nacks, 0);

    // R1: every write-flavoured address byte against straps 2'b10
    for (int b = 0; b < 256; b += 2) begin
      bit exp;
      bus_start();
      put_byte(b[7:0], a);
      bus_stop();
      exp = (b[7:4] == 4'hA) && !b[3] && (b[2:1] == 2'b10);
      chk(a == exp, "R1", $sformatf("addr byte %02h", b), a, exp);
    end
    sel = 2'b01;
    bus_start(); put_byte(8'hA2, a); bus_stop();
    chk(a, "R1", "strap 01 match", a, 1);
    bus_start(); put_byte(8'hA4, a); bus_stop();
    chk(!a, "R1", "strap 01 mismatch", a, 0);
    sel = 2'b10;

    // R4, R5, R8: byte write with junk upper address bits
    wbuf[0] = 8'h5A;
    do_write(16'hF923, 1, "R5");
    ref_mem[11'h123] = 8'h5A;
    poll_ready(nacks);
    chk(nacks >= 1, "R8", "address refused during cycle", nacks, 1);
    chk(nacks < 10, "R8", "address accepted after cycle", nacks, 9);
    rand_read(16'h0123, 1);
    bus_stop();
    chk(rbuf[0] == ref_mem[11'h123], "R4", "read back of 0x123", rbuf[0], ref_mem[11'h123]);

    // R6, R11: 70-byte page write starting at offset 60
    base = 11'h2C0;
    for (int i = 0; i < 70; i++) begin
      wbuf[i] = 8'((i * 7 + 3) & 255);
      ref_mem[{base[10:6], 6'((60 + i) % 64)}] = wbuf[i];
    end
    do_write({5'b0, base + 11'd60}, 70, "R6");
    poll_ready(nacks);
    chk(nacks >= 1, "R8", "cycle after page write", nacks, 1);
    bus_start();
    put_byte(dev_byte(1'b1), a);
    chk(a, "R11", "current read address ack", a, 1);
    get_byte(1'b0, rbuf[0]);
    bus_stop();
    chk(rbuf[0] == ref_mem[base + 11'd2], "R11", "current address after wrap",
        rbuf[0], ref_mem[base + 11'd2]);
    rand_read({5'b0, base}, 64);
    bus_stop();
    for (int i = 0; i < 64; i++)
      chk(rbuf[i] == ref_mem[base + 11'(i)], "R6", $sformatf("page offset %0d", i),
          rbuf[i], ref_mem[base + 11'(i)]);

    // R12: sequential read across the top of memory
    wbuf[0] = 8'hC3; do_write(16'h07FF, 1, "R5"); poll_ready(nacks);
    wbuf[0] = 8'h3C; do_write(16'h0000, 1, "R5"); poll_ready(nacks);
    rand_read(16'h07FF, 2);
    chk(sda_oe == 1'b0, "R12", "SDA released after no-ack", sda_oe, 0);
    bus_stop();
    chk(rbuf[0] == 8'hC3, "R12", "byte at 0x7FF", rbuf[0], 8'hC3);
    chk(rbuf[1] == 8'h3C, "R12", "wrap to 0x000", rbuf[1], 8'h3C);

    // R7: repeated START discards pending data
    wbuf[0] = 8'hAA; do_write(16'h0050, 1, "R5"); poll_ready(nacks);
    addr_write(16'h0050, ok);
    put_byte(8'h55, a);
    bus_start();
    put_byte(dev_byte(1'b0), a);
    bus_stop();
    poll_ready(nacks);
    chk(nacks == 0, "R7", "no cycle after discard", nacks, 0);
    rand_read(16'h0050, 1);
    bus_stop();
    chk(rbuf[0] == 8'hAA, "R7", "memory kept", rbuf[0], 8'hAA);

    // R9: protect gate vetoes the commit
    wbuf[0] = 8'h77; do_write(16'h0060, 1, "R5"); poll_ready(nacks);
    wr_block = 1'b1;
    wbuf[0] = 8'h11; do_write(16'h0060, 1, "R9");
    wr_block = 1'b0;
    poll_ready(nacks);
    chk(nacks == 0, "R9", "no cycle when blocked", nacks, 0);
    rand_read(16'h0060, 1);
    bus_stop();
    chk(rbuf[0] == 8'h77, "R9", "protected byte unchanged", rbuf[0], 8'h77);

    chk(r3_bad == 0, "R3", "drive changes with SCL high", r3_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule